// File: doc/BRIEF.md
# Parallel Lower Bound Unit

This block computes a greedy lower bound on the cost of completing a partial tour in a branch-and-bound search over a small, fully connected graph. After a start strobe it walks every vertex of the graph in order, issuing one table read per cycle. For each vertex the search tables return the following:

- the vertex's own used flag and its partner ("other end") pointer;
- a count of stored candidate edges;
- a row of candidate slots, each holding a neighbour index, a 2-bit weight, an exclusion flag and the neighbour's used flag.

All candidate slots of one vertex are filtered and reduced to a minimum in the same cycle. The unit adds the result to a running bound.

A vertex that is already used adds nothing. Otherwise the cheapest surviving candidate weight is added. If no candidate survives, a fixed penalty of 3 is added. When the last vertex has been accumulated, the unit pulses done. The bound then stays on its output until the next walk begins. The search controller that owns the tables and compares the bound against its best tour sits outside this block.

Top module: `lbound_core`

## Requirements
- R1: Out of reset, bound_o reads 0 and both done_o and rd_en_o are low.
- R2: An accepted start makes rd_en_o high for exactly NUM_VERT consecutive cycles, beginning the cycle after start is sampled. During those cycles rd_addr_o steps through 0, 1, ..., NUM_VERT-1 by one per cycle.
- R3: A vertex whose tbl_used_i is 1 adds 0 to the bound, whatever its candidate slots hold.
- R4: Candidate slot i is valid only if all of the following hold: tbl_nbr_used_i[i] is 0, its neighbour index (tbl_nbr_i bits i*VW and up) differs from tbl_other_i, and tbl_excl_i[i] is 0.
- R5: Slots with index greater than or equal to tbl_ecnt_i never count as valid, whatever they hold.
- R6: For an unused vertex with at least one valid slot, the smallest weight among the valid slots (tbl_wt_i bits i*2 and up) is added to the bound. Lane NUM_LANES-1 takes part in this like any other lane.
- R7: For an unused vertex with no valid slot, exactly 3 is added.
- R8: done_o is a single-cycle pulse, high NUM_VERT+2 cycles after the accepted start edge. At that point bound_o holds the final sum, and the value stays there until the next accepted start.
- R9: A start asserted while a walk is in progress is ignored. The address sequence, the done timing and the final bound are unchanged.
- R10: An accepted start clears the bound, so bound_o reads 0 in the cycle after start is sampled.
- R11: Within a walk the bound never decreases and never grows by more than 3 in one cycle, so the accumulator does not wrap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Begin a walk (ignored while busy) |
| rd_en_o | output | 1 | Table read request for rd_addr_o |
| rd_addr_o | output | VW (4) | Vertex index being read |
| tbl_used_i | input | 1 | Used flag of the read vertex, one cycle after the request |
| tbl_other_i | input | VW (4) | Partner index of the read vertex |
| tbl_ecnt_i | input | CNT_W (5) | Number of stored candidate slots |
| tbl_nbr_i | input | NUM_LANES*VW (80) | Neighbour index per slot |
| tbl_wt_i | input | NUM_LANES*2 (40) | Edge weight per slot |
| tbl_excl_i | input | NUM_LANES (20) | Exclusion flag per slot |
| tbl_nbr_used_i | input | NUM_LANES (20) | Used flag of each slot's neighbour |
| bound_o | output | BOUND_W (10) | Accumulated lower bound |
| done_o | output | 1 | One-cycle completion pulse |

## Verification
On every cycle the assertions check the shape of the walk. Read addresses must advance by one with no restart in the middle, and done must be a lone pulse that lands exactly NUM_VERT+2 cycles after the reads begin. A walk must open with a cleared bound, and the bound must only ever grow, in steps no larger than the penalty. The actual values added per vertex can only be shown by the bench's scenarios, because they depend on the table contents. These scenarios cover used vertices, each of the three rejection reasons, slots past the edge count, empty vertices and a minimum in the last lane. Randomised tables are compared against an independently computed sum, and one scenario shows a mid-walk start being ignored.

// File: rtl/lbound_pkg.sv
package lbound_pkg;

    typedef enum logic [1:0] {
        WALK_IDLE  = 2'd0,
        WALK_ISSUE = 2'd1,
        WALK_DRAIN = 2'd2
    } walk_state_e;

endpackage

// File: rtl/lb_walker.sv
module lb_walker
    import lbound_pkg::*;
#(
    parameter int NUM_VERT = 16,
    parameter int VW       = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start_i,
    output logic          rd_en_o,
    output logic [VW-1:0] rd_addr_o,
    output logic          clr_o,
    output logic          cap_o,
    output logic          acc_o,
    output logic          done_o
);

    localparam logic [VW-1:0] LAST_V = VW'(NUM_VERT - 1);

    typedef struct packed {
        walk_state_e   st;
        logic [VW-1:0] cnt;
        logic          v1;
        logic          l1;
        logic          v2;
        logic          l2;
        logic          done;
    } walk_t;

    walk_t s_d, s_q;
    logic  at_last;

    assign at_last = (s_q.cnt == LAST_V);

    always_comb begin
        s_d   = s_q;
        clr_o = 1'b0;
        // stage tags follow the read data through the datapath
        s_d.v1   = (s_q.st == WALK_ISSUE);
        s_d.l1   = (s_q.st == WALK_ISSUE) && at_last;
        s_d.v2   = s_q.v1;
        s_d.l2   = s_q.l1;
        s_d.done = s_q.l2;
        case (s_q.st)
            WALK_IDLE: begin
                if (start_i) begin
                    s_d.st  = WALK_ISSUE;
                    s_d.cnt = '0;
                    clr_o   = 1'b1;
                end
            end
            WALK_ISSUE: begin
                if (at_last) s_d.st = WALK_DRAIN;
                else         s_d.cnt = s_q.cnt + 1'b1;
            end
            WALK_DRAIN: begin
                if (s_q.l2) s_d.st = WALK_IDLE;
            end
            default: s_d.st = WALK_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign rd_en_o   = (s_q.st == WALK_ISSUE);
    assign rd_addr_o = s_q.cnt;
    assign cap_o     = s_q.v1;
    assign acc_o     = s_q.v2;
    assign done_o    = s_q.done;

endmodule

// File: rtl/lb_lane_filter.sv
module lb_lane_filter #(
    parameter int LANE  = 0,
    parameter int VW    = 4,
    parameter int CNT_W = 5
) (
    input  logic [VW-1:0]    nbr_i,
    input  logic [VW-1:0]    other_i,
    input  logic [CNT_W-1:0] ecnt_i,
    input  logic             excl_i,
    input  logic             nbr_used_i,
    output logic             valid_o
);

    localparam logic [CNT_W-1:0] LANE_IDX = CNT_W'(LANE);

    logic in_range;
    logic free_nbr;
    logic not_partner;

    assign in_range    = (LANE_IDX < ecnt_i);
    assign free_nbr    = !nbr_used_i;
    assign not_partner = (nbr_i != other_i);
    assign valid_o     = in_range && free_nbr && not_partner && !excl_i;

endmodule

// File: rtl/lb_min_tree.sv
module lb_min_tree #(
    parameter int LANES = 20,
    parameter int W_W   = 2
) (
    input  logic [LANES-1:0]     valid_i,
    input  logic [LANES*W_W-1:0] wt_i,
    output logic                 any_o,
    output logic [W_W-1:0]       min_o
);

    localparam int DEPTH  = (LANES > 1) ? $clog2(LANES) : 1;
    localparam int LEAVES = 1 << DEPTH;

    logic           node_v [1:2*LEAVES-1];
    logic [W_W-1:0] node_w [1:2*LEAVES-1];

    for (genvar i = 0; i < LEAVES; i++) begin : g_leaf
        if (i < LANES) begin : g_real
            assign node_v[LEAVES+i] = valid_i[i];
            assign node_w[LEAVES+i] = wt_i[i*W_W +: W_W];
        end else begin : g_pad
            assign node_v[LEAVES+i] = 1'b0;
            assign node_w[LEAVES+i] = '1;
        end
    end

    for (genvar k = 1; k < LEAVES; k++) begin : g_node
        logic take_left;
        assign take_left = node_v[2*k] &&
                           (!node_v[2*k+1] || (node_w[2*k] <= node_w[2*k+1]));
        assign node_v[k] = node_v[2*k] || node_v[2*k+1];
        assign node_w[k] = take_left ? node_w[2*k] : node_w[2*k+1];
    end

    assign any_o = node_v[1];
    assign min_o = node_w[1];

endmodule

// File: rtl/lbound_core.sv
module lbound_core
    import lbound_pkg::*;
#(
    parameter int NUM_VERT  = 16,
    parameter int NUM_LANES = 20,
    parameter int W_W       = 2,
    parameter int BOUND_W   = 10,
    parameter int PENALTY   = 3,
    parameter int VW        = (NUM_VERT > 1) ? $clog2(NUM_VERT) : 1,
    parameter int CNT_W     = $clog2(NUM_LANES + 1)
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     start_i,
    output logic                     rd_en_o,
    output logic [VW-1:0]            rd_addr_o,
    input  logic                     tbl_used_i,
    input  logic [VW-1:0]            tbl_other_i,
    input  logic [CNT_W-1:0]         tbl_ecnt_i,
    input  logic [NUM_LANES*VW-1:0]  tbl_nbr_i,
    input  logic [NUM_LANES*W_W-1:0] tbl_wt_i,
    input  logic [NUM_LANES-1:0]     tbl_excl_i,
    input  logic [NUM_LANES-1:0]     tbl_nbr_used_i,
    output logic [BOUND_W-1:0]       bound_o,
    output logic                     done_o
);

    localparam int PEN_W = $clog2(PENALTY + 1);
    localparam int CON_W = (W_W > PEN_W) ? W_W : PEN_W;
    localparam logic [CON_W-1:0] PEN_V = CON_W'(PENALTY);

    typedef struct packed {
        logic [BOUND_W-1:0] bound;
        logic [CON_W-1:0]   contrib;
    } acc_t;

    logic                 clr, cap, acc;
    logic [NUM_LANES-1:0] lane_ok;
    logic                 any_ok;
    logic [W_W-1:0]       min_w;
    logic [CON_W-1:0]     contrib_c;
    acc_t                 a_d, a_q;

    lb_walker #(
        .NUM_VERT (NUM_VERT),
        .VW       (VW)
    ) u_walk (
        .clk       (clk),
        .rst_n     (rst_n),
        .start_i   (start_i),
        .rd_en_o   (rd_en_o),
        .rd_addr_o (rd_addr_o),
        .clr_o     (clr),
        .cap_o     (cap),
        .acc_o     (acc),
        .done_o    (done_o)
    );

    for (genvar i = 0; i < NUM_LANES; i++) begin : g_lane
        lb_lane_filter #(
            .LANE  (i),
            .VW    (VW),
            .CNT_W (CNT_W)
        ) u_filt (
            .nbr_i      (tbl_nbr_i[i*VW +: VW]),
            .other_i    (tbl_other_i),
            .ecnt_i     (tbl_ecnt_i),
            .excl_i     (tbl_excl_i[i]),
            .nbr_used_i (tbl_nbr_used_i[i]),
            .valid_o    (lane_ok[i])
        );
    end

    lb_min_tree #(
        .LANES (NUM_LANES),
        .W_W   (W_W)
    ) u_tree (
        .valid_i (lane_ok),
        .wt_i    (tbl_wt_i),
        .any_o   (any_ok),
        .min_o   (min_w)
    );

    always_comb begin
        if (tbl_used_i)  contrib_c = '0;
        else if (any_ok) contrib_c = CON_W'(min_w);
        else             contrib_c = PEN_V;
    end

    always_comb begin
        a_d = a_q;
        if (cap) a_d.contrib = contrib_c;
        if (clr)      a_d.bound = '0;
        else if (acc) a_d.bound = a_q.bound + BOUND_W'(a_q.contrib);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) a_q <= '0;
        else        a_q <= a_d;
    end

    assign bound_o = a_q.bound;

endmodule

// File: rtl/lbound_checker.sv
module lbound_checker #(
    parameter int NUM_VERT = 16,
    parameter int VW       = 4,
    parameter int BOUND_W  = 10,
    parameter int PENALTY  = 3
) (
    input logic               clk,
    input logic               rst_n,
    input logic               rd_en,
    input logic [VW-1:0]      rd_addr,
    input logic [BOUND_W-1:0] bound,
    input logic               done
);

    localparam logic [VW-1:0] LAST_V = VW'(NUM_VERT - 1);

    logic        rd_en_prev;
    logic [31:0] since_rise;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_en_prev <= 1'b0;
            since_rise <= '0;
        end else begin
            rd_en_prev <= rd_en;
            if (rd_en && !rd_en_prev)   since_rise <= 32'd1;
            else if (since_rise != '0)  since_rise <= since_rise + 32'd1;
        end
    end

    // R2 / R9: reads advance one vertex per cycle, no restart mid-walk
    a_r2_addr_step: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && rd_addr != LAST_V) |=> (rd_en && rd_addr == $past(rd_addr) + 1'b1));

    a_r9_no_restart: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && $past(rd_en)) |-> (rd_addr != '0));

    a_r2_first_addr: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rd_en) |-> (rd_addr == '0));

    // R10: each walk opens on a cleared bound
    a_r10_clear: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rd_en) |-> (bound == '0));

    // R8: single pulse at the fixed distance from the first read
    a_r8_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    a_r8_done_latency: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (since_rise == 32'(NUM_VERT + 2) && !rd_en));

    // R11: growth only, bounded per step
    a_r11_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
        (bound != $past(bound) && bound != '0) |->
        (bound > $past(bound) && (bound - $past(bound)) <= BOUND_W'(PENALTY)));

    // R8: bound steady once a walk has finished
    a_r8_hold: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(done) && !rd_en) |-> (bound == $past(bound)));

endmodule

bind lbound_core lbound_checker #(
    .NUM_VERT (NUM_VERT),
    .VW       (VW),
    .BOUND_W  (BOUND_W),
    .PENALTY  (PENALTY)
) u_lbound_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .rd_en   (rd_en_o),
    .rd_addr (rd_addr_o),
    .bound   (bound_o),
    .done    (done_o)
);

// File: tb/lbound_core_bench.sv
module lbound_core_bench;

    localparam int NV = 16;
    localparam int NL = 20;
    localparam int VW = 4;
    localparam int CW = 5;
    localparam int BW = 10;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0;
    logic rd_en;
    logic [VW-1:0] rd_addr;
    logic tbl_used = 1'b0;
    logic [VW-1:0] tbl_other = '0;
    logic [CW-1:0] tbl_ecnt = '0;
    logic [NL*VW-1:0] tbl_nbr = '0;
    logic [NL*2-1:0] tbl_wt = '0;
    logic [NL-1:0] tbl_excl = '0;
    logic [NL-1:0] tbl_nbr_used = '0;
    logic [BW-1:0] bound;
    logic done;

    logic          used_m  [NV];
    logic [VW-1:0] other_m [NV];
    int            ecnt_m  [NV];
    logic [VW-1:0] nbr_m   [NV][NL];
    logic [1:0]    wt_m    [NV][NL];
    logic          excl_m  [NV][NL];

    int n_chk = 0;
    int n_fail = 0;
    bit finished = 1'b0;

    always #2 clk = ~clk;

    lbound_core u_lbound_core (
        .clk(clk), .rst_n(rst_n), .start_i(start),
        .rd_en_o(rd_en), .rd_addr_o(rd_addr),
        .tbl_used_i(tbl_used), .tbl_other_i(tbl_other), .tbl_ecnt_i(tbl_ecnt),
        .tbl_nbr_i(tbl_nbr), .tbl_wt_i(tbl_wt), .tbl_excl_i(tbl_excl),
        .tbl_nbr_used_i(tbl_nbr_used), .bound_o(bound), .done_o(done)
    );

    // synchronous table model: data one cycle after the request
    always @(posedge clk) begin
        if (rd_en) begin
            tbl_used  <= used_m[rd_addr];
            tbl_other <= other_m[rd_addr];
            tbl_ecnt  <= CW'(ecnt_m[rd_addr]);
            for (int i = 0; i < NL; i++) begin
                tbl_nbr[i*VW +: VW] <= nbr_m[rd_addr][i];
                tbl_wt[i*2 +: 2]    <= wt_m[rd_addr][i];
                tbl_excl[i]         <= excl_m[rd_addr][i];
                tbl_nbr_used[i]     <= used_m[nbr_m[rd_addr][i]];
            end
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic int ref_bound();
        int s = 0;
        for (int v = 0; v < NV; v++) begin
            if (!used_m[v]) begin
                int best = 4;
                for (int i = 0; i < ecnt_m[v]; i++) begin
                    if (!used_m[nbr_m[v][i]] && nbr_m[v][i] != other_m[v] &&
                        !excl_m[v][i] && int'(wt_m[v][i]) < best)
                        best = int'(wt_m[v][i]);
                end
                s += (best == 4) ? 3 : best;
            end
        end
        return s;
    endfunction

    task automatic clear_tables(input bit all_used);
        for (int v = 0; v < NV; v++) begin
            used_m[v] = all_used;
            other_m[v] = VW'(v ^ 1);
            ecnt_m[v] = 0;
            for (int i = 0; i < NL; i++) begin
                nbr_m[v][i] = '0;
                wt_m[v][i] = 2'd3;
                excl_m[v][i] = 1'b0;
            end
        end
    endtask

    task automatic rand_tables();
        for (int v = 0; v < NV; v++) begin
            used_m[v] = ($urandom % 4) == 0;
            other_m[v] = VW'($urandom % NV);
            ecnt_m[v] = $urandom % (NL + 1);
            for (int i = 0; i < NL; i++) begin
                nbr_m[v][i] = VW'($urandom % NV);
                wt_m[v][i] = 2'($urandom % 4);
                excl_m[v][i] = ($urandom % 8) == 0;
            end
        end
    endtask

    // one walk; optional start pulse in the middle (R9)
    task automatic run_walk(input string req, input bit inject);
        int exp = ref_bound();
        int k = 0;
        int reads = 0;
        int exp_addr = 0;
        bit seen = 1'b0;
        @(negedge clk); start = 1'b1;
        @(posedge clk);
        @(negedge clk); start = 1'b0;
        chk(bound == '0, "R10 bound cleared", int'(bound), 0);
        while (k < NV + 10) begin
            if (rd_en) begin
                chk(int'(rd_addr) == exp_addr, "R2 address order", int'(rd_addr), exp_addr);
                exp_addr++;
                reads++;
            end
            if (done) begin seen = 1'b1; break; end
            if (inject && k == 3) start = 1'b1;
            if (inject && k == 4) start = 1'b0;
            @(posedge clk); k++;
            @(negedge clk);
        end
        start = 1'b0;
        chk(seen && k == NV + 2, "R8 done latency", k, NV + 2);
        chk(reads == NV, inject ? "R9 reads with mid-walk start" : "R2 read count", reads, NV);
        chk(int'(bound) == exp, req, int'(bound), exp);
        @(negedge clk);
        chk(!done, "R8 done single pulse", int'(done), 0);
        chk(int'(bound) == exp && !rd_en, inject ? "R9 no restart" : "R8 bound held",
            int'(bound), exp);
    endtask

    initial begin
        void'($urandom(32'd4242));
        clear_tables(1'b1);
        repeat (3) @(negedge clk);
        chk(bound == '0, "R1 reset bound", int'(bound), 0);
        chk(!done, "R1 reset done", int'(done), 0);
        chk(!rd_en, "R1 reset rd_en", int'(rd_en), 0);
        rst_n = 1'b1;
        @(negedge clk);

        // R3: every vertex used, rich candidate rows still add nothing
        clear_tables(1'b1);
        for (int v = 0; v < NV; v++) begin
            ecnt_m[v] = NL;
            for (int i = 0; i < NL; i++) wt_m[v][i] = 2'd0;
        end
        run_walk("R3 used vertices add zero", 1'b0);

        // R7: nobody used, no candidates anywhere -> 3 per vertex
        clear_tables(1'b0);
        run_walk("R7 empty vertices penalty", 1'b0);

        // R5/R6: vertex 0 with two live slots, a cheaper slot past the count
        clear_tables(1'b1);
        used_m[0] = 1'b0; used_m[2] = 1'b0; used_m[3] = 1'b0;
        other_m[0] = 4'd9;
        ecnt_m[0] = 2;
        nbr_m[0][0] = 4'd2; wt_m[0][0] = 2'd2;
        nbr_m[0][1] = 4'd3; wt_m[0][1] = 2'd1;
        nbr_m[0][5] = 4'd2; wt_m[0][5] = 2'd0;
        run_walk("R6 minimum of valid slots, R5 slot past count ignored", 1'b0);

        // R4: excluded slot rejected
        excl_m[0][1] = 1'b1;
        run_walk("R4 excluded slot rejected", 1'b0);

        // R4: partner neighbour rejected
        excl_m[0][1] = 1'b0;
        other_m[0] = 4'd3;
        run_walk("R4 partner slot rejected", 1'b0);

        // R4: used neighbour rejected
        other_m[0] = 4'd9;
        used_m[3] = 1'b1;
        run_walk("R4 used neighbour rejected", 1'b0);

        // R6: full row, unique minimum in the last lane
        clear_tables(1'b1);
        used_m[0] = 1'b0; used_m[1] = 1'b0;
        other_m[0] = 4'd15;
        ecnt_m[0] = NL;
        for (int i = 0; i < NL; i++) begin nbr_m[0][i] = 4'd1; wt_m[0][i] = 2'd2; end
        wt_m[0][NL-1] = 2'd0;
        run_walk("R6 minimum in last lane", 1'b0);

        // R9: start pulse in the middle of a walk
        rand_tables();
        run_walk("R9 bound with mid-walk start", 1'b1);

        // random tables: R3..R7 and R11 together
        for (int t = 0; t < 30; t++) begin
            rand_tables();
            run_walk("R11 random walk sum", (t % 7) == 3);
        end

        finished = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

endmodule